// File: doc/BRIEF.md
# Digital Peak Level Limiter

This block controls the level of a signed audio sample stream. Each accepted sample is scaled by a gain word that comes from an attenuation count in sixteenth-decibel steps. The scaled sample leaves the block one clock later. The magnitude of each scaled sample is compared against a peak ceiling picked by a 3-bit code. While the latest scaled sample sits above the ceiling, the attenuation climbs one step per attack interval. Once it falls back to or under the ceiling, the attenuation unwinds one step per release interval. The gain therefore glides rather than clipping.

Attenuation never goes beyond 8 dB. An input loud enough to need more than that still leaves the block 8 dB down, but it is no longer pinned at the ceiling. Limiting runs only when the host-control mode input and the boost input are both high and the ceiling code names a real level. In every other case the samples pass through untouched and the attenuation is cleared at once. Step intervals are derived from the clock rate parameter, so the same block works at any system clock.

Top module: `peak_limiter`

## Requirements
- R1: The limiter is inactive when `soft_mode` is 0, when `boost_en` is 0, or when `thr_code` is 000 or 111. While it is inactive, `atten` reads 0 from the next clock, and every output sample equals its input sample exactly.
- R2: A sample presented with `in_vld` high appears on `out_smp`, with `out_vld` high, one clock later. Its value is within 3 LSB of in × 10^(−A/320), where A is the `atten` value shown while the sample was presented. With A = 0 it is exact. `out_vld` is low one clock after `in_vld` is low.
- R3: `atten` counts in 1/16 dB units and stays within 0 to 128 (8 dB). Under sustained overload it saturates and holds at 128.
- R4: Ceiling codes 001 to 110 stand for 14, 17, 20, 22, 25 and 28 Vpp. The ceiling is floor(V × (2^(W−1)−1) / FS_VPP), with FS_VPP = 40 by default. A scaled sample is over only when its magnitude exceeds the ceiling; equal does not count. Under steady input the attenuation settles where the output just drops under the ceiling.
- R5: While over, `atten` rises by one every La clocks. La = max(1, floor(T × CLK_KHZ / 96000)), where T is 830, 1200, 1500 or 2200 µs for `atk_code` 00, 01, 10 or 11. This spreads 6 dB over time T.
- R6: While not over and `atten` is above 0, `atten` falls by one every Lr clocks. Lr uses the same formula with T = 500000, 380000, 210000 or 170000 µs for `rel_code` 00, 01, 10 or 11.
- R7: The over state is decided by the most recent valid sample. Clocks with `in_vld` low keep it, so a running attack continues through a gap.
- R8: While active, `atten` changes by at most one step per clock.
- R9: After reset, `atten` is 0, `out_vld` is 0 and `out_smp` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_vld | input | 1 | Input sample qualifier |
| in_smp | input | DATA_W | Signed input sample |
| soft_mode | input | 1 | Host-control mode; limiter allowed only when high |
| boost_en | input | 1 | Boost state; limiter allowed only when high |
| thr_code | input | 3 | Peak ceiling select (000 and 111 = off) |
| atk_code | input | 2 | Attack interval select |
| rel_code | input | 2 | Release interval select |
| out_vld | output | 1 | Output sample qualifier |
| out_smp | output | DATA_W | Signed scaled sample |
| atten | output | 8 | Current attenuation in 1/16 dB |

## Verification
A wrong step counter or direction decision shows at `atten` within one attack or release interval. The bench therefore measures the exact clock spacing between successive attenuation changes for several codes. A bad gain word shows on the very next output sample, because each sample is compared against the attenuation that was visible while it was presented. A faulty ceiling compare or a mis-kept over state shows as a wrong settling point under steady overload, or as a stalled attack across an invalid-sample gap, within a few dozen clocks.

// File: rtl/peak_lim_pkg.sv
package peak_lim_pkg;

    localparam int GAIN_W   = 16;
    localparam int GAIN_ONE = 32768;
    localparam int FRAC_SH  = 15;

    typedef enum logic [1:0] {
        DIR_IDLE = 2'd0,
        DIR_ATK  = 2'd1,
        DIR_REL  = 2'd2
    } dir_e;

    // Ceiling level in sample units for a 3-bit code; 0 for the "off" codes.
    function automatic longint ceil_level(input logic [2:0] code, input int data_w,
                                          input int fs_vpp);
        longint vpp;
        case (code)
            3'd1: vpp = 14;
            3'd2: vpp = 17;
            3'd3: vpp = 20;
            3'd4: vpp = 22;
            3'd5: vpp = 25;
            3'd6: vpp = 28;
            default: vpp = 0;
        endcase
        return (vpp * ((longint'(1) << (data_w - 1)) - 1)) / longint'(fs_vpp);
    endfunction

    // Clocks per 1/16 dB step: 96 steps span 6 dB over the nominal time.
    function automatic longint step_clocks(input logic is_rel, input logic [1:0] code,
                                           input longint clk_khz);
        longint t_us;
        longint v;
        if (is_rel) begin
            case (code)
                2'd0: t_us = 500000;
                2'd1: t_us = 380000;
                2'd2: t_us = 210000;
                default: t_us = 170000;
            endcase
        end else begin
            case (code)
                2'd0: t_us = 830;
                2'd1: t_us = 1200;
                2'd2: t_us = 1500;
                default: t_us = 2200;
            endcase
        end
        v = (t_us * clk_khz) / 96000;
        return (v < 1) ? 1 : v;
    endfunction

endpackage

// File: rtl/peak_lim_gain.sv
module peak_lim_gain
    import peak_lim_pkg::*;
#(
    parameter int ATT_W = 8
) (
    input  logic [ATT_W-1:0]  atten_i,
    output logic [GAIN_W-1:0] gain_o
);
    localparam int CRS_W = ATT_W - 4;

    logic [CRS_W-1:0] crs_idx;
    logic [3:0]       fin_idx;
    logic [16:0]      crs_g;
    logic [16:0]      fin_g;
    logic [33:0]      prod;

    assign crs_idx = atten_i[ATT_W-1:4];
    assign fin_idx = atten_i[3:0];

    // Whole-dB part: 10^(-i/20) in Q1.15
    always_comb begin
        case (4'(crs_idx))
            4'd0: crs_g = 17'd32768;
            4'd1: crs_g = 17'd29205;
            4'd2: crs_g = 17'd26029;
            4'd3: crs_g = 17'd23198;
            4'd4: crs_g = 17'd20675;
            4'd5: crs_g = 17'd18427;
            4'd6: crs_g = 17'd16423;
            4'd7: crs_g = 17'd14637;
            default: crs_g = 17'd13045;
        endcase
    end

    // Sixteenth-dB part: 10^(-f/320) in Q1.15
    always_comb begin
        case (fin_idx)
            4'd0:  fin_g = 17'd32768;
            4'd1:  fin_g = 17'd32533;
            4'd2:  fin_g = 17'd32300;
            4'd3:  fin_g = 17'd32068;
            4'd4:  fin_g = 17'd31838;
            4'd5:  fin_g = 17'd31610;
            4'd6:  fin_g = 17'd31383;
            4'd7:  fin_g = 17'd31158;
            4'd8:  fin_g = 17'd30935;
            4'd9:  fin_g = 17'd30713;
            4'd10: fin_g = 17'd30493;
            4'd11: fin_g = 17'd30274;
            4'd12: fin_g = 17'd30057;
            4'd13: fin_g = 17'd29842;
            4'd14: fin_g = 17'd29628;
            default: fin_g = 17'd29415;
        endcase
    end

    always_comb begin
        prod   = 34'(crs_g) * 34'(fin_g) + 34'(1 << (FRAC_SH - 1));
        gain_o = GAIN_W'(prod >> FRAC_SH);
    end

endmodule

// File: rtl/peak_lim_rate.sv
module peak_lim_rate
    import peak_lim_pkg::*;
#(
    parameter longint CLK_KHZ   = 125000,
    parameter int     ATTEN_MAX = 128
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             active_i,
    input  logic                             over_i,
    input  logic [1:0]                       atk_code_i,
    input  logic [1:0]                       rel_code_i,
    output logic [$clog2(ATTEN_MAX+1)-1:0]   atten_o
);
    localparam int ATT_W = $clog2(ATTEN_MAX + 1);
    localparam int CNT_W = $clog2(step_clocks(1'b1, 2'd0, CLK_KHZ)) + 1;

    typedef struct packed {
        dir_e             dir;
        logic [CNT_W-1:0] cnt;
        logic [ATT_W-1:0] atten;
    } rate_st_t;

    rate_st_t st_d, st_q;

    logic [CNT_W-1:0] atk_len [4];
    logic [CNT_W-1:0] rel_len [4];
    logic [CNT_W-1:0] len_sel;
    dir_e             dir_want;

    for (genvar g = 0; g < 4; g++) begin : g_len
        assign atk_len[g] = CNT_W'(step_clocks(1'b0, 2'(g), CLK_KHZ));
        assign rel_len[g] = CNT_W'(step_clocks(1'b1, 2'(g), CLK_KHZ));
    end

    always_comb begin
        len_sel = over_i ? atk_len[atk_code_i] : rel_len[rel_code_i];
        if (over_i && st_q.atten < ATT_W'(ATTEN_MAX))
            dir_want = DIR_ATK;
        else if (!over_i && st_q.atten != '0)
            dir_want = DIR_REL;
        else
            dir_want = DIR_IDLE;
    end

    always_comb begin
        st_d = st_q;
        if (!active_i) begin
            st_d.dir   = DIR_IDLE;
            st_d.cnt   = '0;
            st_d.atten = '0;
        end else if (dir_want == DIR_IDLE || dir_want != st_q.dir) begin
            st_d.dir = dir_want;
            st_d.cnt = '0;
        end else if (st_q.cnt >= len_sel - CNT_W'(1)) begin
            st_d.cnt = '0;
            if (dir_want == DIR_ATK)
                st_d.atten = st_q.atten + ATT_W'(1);
            else
                st_d.atten = st_q.atten - ATT_W'(1);
        end else begin
            st_d.cnt = st_q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            st_q <= '0;
        else
            st_q <= st_d;
    end

    assign atten_o = st_q.atten;

    // R3: attenuation never leaves its range
    a_r3_atten_cap: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.atten <= ATT_W'(ATTEN_MAX));

    // R1: inactive clears the attenuation on the next clock
    a_r1_clear: assert property (@(posedge clk) disable iff (!rst_n)
        !active_i |=> st_q.atten == '0);

    // R8: at most one step per clock while active
    a_r8_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        active_i |=> ((ATT_W+1)'(st_q.atten) <= (ATT_W+1)'($past(st_q.atten)) + 1)
                  && ((ATT_W+1)'(st_q.atten) + 1 >= (ATT_W+1)'($past(st_q.atten))));

    // R5: attenuation never rises while the output is under the ceiling
    a_r5_no_rise_cool: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && !over_i) |=> st_q.atten <= $past(st_q.atten));

endmodule

// File: rtl/peak_limiter.sv
module peak_limiter
    import peak_lim_pkg::*;
#(
    parameter int     DATA_W    = 16,
    parameter longint CLK_KHZ   = 125000,
    parameter int     FS_VPP    = 40,
    parameter int     ATTEN_MAX = 128
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_vld,
    input  logic [DATA_W-1:0]    in_smp,
    input  logic                 soft_mode,
    input  logic                 boost_en,
    input  logic [2:0]           thr_code,
    input  logic [1:0]           atk_code,
    input  logic [1:0]           rel_code,
    output logic                 out_vld,
    output logic [DATA_W-1:0]    out_smp,
    output logic [7:0]           atten
);
    localparam int ATT_W  = $clog2(ATTEN_MAX + 1);
    localparam int PROD_W = DATA_W + GAIN_W + 1;

    typedef struct packed {
        logic [DATA_W-1:0] smp;
        logic              vld;
        logic              over;
    } dp_st_t;

    dp_st_t dp_d, dp_q;

    logic [DATA_W:0]        ceil_tab [8];
    logic [DATA_W:0]        ceil_sel;
    logic                   active;
    logic [ATT_W-1:0]       att_q;
    logic [GAIN_W-1:0]      gain;
    logic signed [PROD_W-1:0] prod;
    logic [DATA_W-1:0]      scaled;
    logic [DATA_W:0]        mag;

    for (genvar c = 0; c < 8; c++) begin : g_ceil
        assign ceil_tab[c] = (DATA_W+1)'(ceil_level(3'(c), DATA_W, FS_VPP));
    end

    assign ceil_sel = ceil_tab[thr_code];
    assign active   = soft_mode && boost_en && (thr_code != 3'd0) && (thr_code != 3'd7);

    peak_lim_gain #(
        .ATT_W (ATT_W)
    ) u_gain (
        .atten_i (att_q),
        .gain_o  (gain)
    );

    peak_lim_rate #(
        .CLK_KHZ   (CLK_KHZ),
        .ATTEN_MAX (ATTEN_MAX)
    ) u_rate (
        .clk        (clk),
        .rst_n      (rst_n),
        .active_i   (active),
        .over_i     (dp_q.over),
        .atk_code_i (atk_code),
        .rel_code_i (rel_code),
        .atten_o    (att_q)
    );

    always_comb begin
        prod   = $signed(in_smp) * $signed({1'b0, gain});
        scaled = DATA_W'(prod >>> FRAC_SH);
        mag    = scaled[DATA_W-1] ? (DATA_W+1)'(-{scaled[DATA_W-1], scaled})
                                  : {1'b0, scaled};
    end

    always_comb begin
        dp_d     = dp_q;
        dp_d.vld = in_vld;
        if (in_vld)
            dp_d.smp = scaled;
        if (!active)
            dp_d.over = 1'b0;
        else if (in_vld)
            dp_d.over = (mag > ceil_sel);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            dp_q <= '0;
        else
            dp_q <= dp_d;
    end

    assign out_vld = dp_q.vld;
    assign out_smp = dp_q.smp;
    assign atten   = 8'(att_q);

    // R2: one-clock latency of the qualifier
    a_r2_vld_follow: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld);

    a_r2_vld_low: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld);

    // R1: zero attenuation passes the sample unchanged
    a_r1_unity: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && att_q == '0) |=> out_smp == $past(in_smp));

    // R7: over state kept through clocks without a sample
    a_r7_hold_over: assert property (@(posedge clk) disable iff (!rst_n)
        (active && !in_vld) |=> $stable(dp_q.over));

endmodule

// File: tb/peak_limiter_tb.sv
module peak_limiter_tb;

    localparam longint CLK_KHZ = 400;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_vld = 1'b0;
    logic [15:0] in_smp = '0;
    logic        soft_mode = 1'b0;
    logic        boost_en = 1'b0;
    logic [2:0]  thr_code = 3'd0;
    logic [1:0]  atk_code = 2'd0;
    logic [1:0]  rel_code = 2'd0;
    logic        out_vld;
    logic [15:0] out_smp;
    logic [7:0]  atten;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    peak_limiter #(
        .DATA_W (16), .CLK_KHZ (CLK_KHZ), .FS_VPP (40), .ATTEN_MAX (128)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .in_vld (in_vld), .in_smp (in_smp),
        .soft_mode (soft_mode), .boost_en (boost_en), .thr_code (thr_code),
        .atk_code (atk_code), .rel_code (rel_code),
        .out_vld (out_vld), .out_smp (out_smp), .atten (atten)
    );

    function automatic longint ceil_of(input int code);
        int v;
        case (code)
            1: v = 14; 2: v = 17; 3: v = 20; 4: v = 22; 5: v = 25; 6: v = 28;
            default: v = 0;
        endcase
        return (longint'(v) * 32767) / 40;
    endfunction

    function automatic int len_of(input bit rel, input int code);
        longint us;
        longint v;
        if (rel) us = (code == 0) ? 500000 : (code == 1) ? 380000 : (code == 2) ? 210000 : 170000;
        else     us = (code == 0) ? 830 : (code == 1) ? 1200 : (code == 2) ? 1500 : 2200;
        v = us * CLK_KHZ / 96000;
        return (v < 1) ? 1 : int'(v);
    endfunction

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // One clock: drive, then check at the following falling edge
    task automatic cycle(input bit v, input longint x);
        int a0;
        bit act0;
        real e;
        real d;
        longint o;
        a0 = int'(atten);
        act0 = soft_mode && boost_en && thr_code != 3'd0 && thr_code != 3'd7;
        in_vld = v;
        in_smp = x[15:0];
        @(negedge clk);
        if (v) begin
            chk(out_vld == 1'b1, "R2 out_vld", longint'(out_vld), 1);
            o = longint'($signed(out_smp));
            if (a0 == 0) begin
                chk(o == x, "R2 unity sample", o, x);
            end else begin
                e = real'(x) * (10.0 ** (-real'(a0) / 320.0));
                d = real'(o) - e;
                if (d < 0.0) d = -d;
                chk(d <= 3.0, "R2 scaled sample", o, longint'(e));
            end
        end else begin
            chk(out_vld == 1'b0, "R2 out_vld low", longint'(out_vld), 0);
        end
        chk(atten <= 8'd128, "R3 range", longint'(atten), 128);
        if (!act0)
            chk(atten == 8'd0, "R1 cleared when inactive", longint'(atten), 0);
        else
            chk((int'(atten) - a0 <= 1) && (a0 - int'(atten) <= 1), "R8 single step",
                longint'(atten), longint'(a0));
    endtask

    task automatic measure(input bit up, input longint x, input int len, input int skip,
                           input int n, input string tag);
        int cnt = 0;
        int seen = 0;
        int guard = 0;
        int prev;
        prev = int'(atten);
        while (seen < skip + n && guard < 20000) begin
            cycle(1'b1, x);
            cnt++;
            guard++;
            if (int'(atten) != prev) begin
                chk(up ? (int'(atten) > prev) : (int'(atten) < prev), {tag, " direction"},
                    longint'(atten), longint'(prev));
                if (seen >= skip) chk(cnt == len, tag, cnt, len);
                seen++;
                cnt = 0;
                prev = int'(atten);
            end
        end
        if (seen < skip + n) chk(1'b0, {tag, " stalled"}, seen, skip + n);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
            report();
        end
    end

    initial begin
        int a0;
        void'($urandom(32'd2024));
        repeat (3) @(negedge clk);
        // R9: reset state
        chk(atten == 8'd0, "R9 reset atten", longint'(atten), 0);
        chk(out_vld == 1'b0, "R9 reset out_vld", longint'(out_vld), 0);
        chk(out_smp == 16'd0, "R9 reset out_smp", longint'(out_smp), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: each gating condition keeps unity gain under overload
        soft_mode = 1'b0; boost_en = 1'b1; thr_code = 3'd1;
        repeat (30) cycle(1'b1, 32767);
        soft_mode = 1'b1; boost_en = 1'b0;
        repeat (30) cycle(1'b1, -32768);
        boost_en = 1'b1; thr_code = 3'd0;
        repeat (30) cycle(1'b1, 32767);
        thr_code = 3'd7;
        repeat (30) cycle(1'b1, 32767);
        chk(atten == 8'd0, "R1 off codes", longint'(atten), 0);

        // R4: ceiling compare boundary (code 011), attack code 11
        thr_code = 3'd3; atk_code = 2'd3; rel_code = 2'd3;
        repeat (30) cycle(1'b1, ceil_of(3));
        chk(atten == 8'd0, "R4 equal to ceiling not over", longint'(atten), 0);
        repeat (len_of(0, 3) + 5) cycle(1'b1, ceil_of(3) + 1);
        chk(atten > 8'd0, "R4 above ceiling attacks", longint'(atten), 1);
        thr_code = 3'd0; cycle(1'b0, 0); thr_code = 3'd3;
        repeat (30) cycle(1'b1, -ceil_of(3));
        chk(atten == 8'd0, "R4 negative equal not over", longint'(atten), 0);
        repeat (len_of(0, 3) + 5) cycle(1'b1, -ceil_of(3) - 1);
        chk(atten > 8'd0, "R4 negative above ceiling", longint'(atten), 1);
        thr_code = 3'd0; cycle(1'b0, 0);

        // R5: attack step spacing for two codes
        thr_code = 3'd1; atk_code = 2'd0; rel_code = 2'd3;
        measure(1'b1, 32767, len_of(0, 0), 1, 4, "R5 attack code 00");
        atk_code = 2'd2;
        measure(1'b1, 32767, len_of(0, 2), 0, 3, "R5 attack code 10");

        // R7: gap without samples keeps the attack running
        a0 = int'(atten);
        repeat (20) cycle(1'b0, 0);
        chk(int'(atten) > a0, "R7 over held through gap", longint'(atten), longint'(a0 + 1));

        // R3: saturation at 8 dB under heavy overload
        atk_code = 2'd0;
        repeat (420) cycle(1'b1, 32767);
        chk(atten == 8'd128, "R3 saturates", longint'(atten), 128);
        repeat (40) cycle(1'b1, -32768);
        chk(atten == 8'd128, "R3 holds at cap", longint'(atten), 128);

        // R6: release step spacing for two codes
        measure(1'b0, 0, len_of(1, 3), 1, 2, "R6 release code 11");
        rel_code = 2'd2;
        measure(1'b0, 0, len_of(1, 2), 0, 1, "R6 release code 10");

        // R1: dropping boost clears at once
        boost_en = 1'b0;
        cycle(1'b1, 1000);
        chk(atten == 8'd0, "R1 boost drop clears", longint'(atten), 0);

        // R4: steady overload settles just under ceiling code 110
        boost_en = 1'b1; thr_code = 3'd6; atk_code = 2'd0; rel_code = 2'd3;
        repeat (400) cycle(1'b1, 32767);
        chk(atten == 8'd50, "R4 regulation point", longint'(atten), 50);

        // Random stimulus
        for (int i = 0; i < 4000; i++) begin
            if (i % 250 == 0) begin
                soft_mode = ($urandom % 8) != 0;
                boost_en  = ($urandom % 8) != 0;
                thr_code  = 3'($urandom % 8);
                atk_code  = 2'($urandom % 4);
                rel_code  = 2'($urandom % 4);
            end
            cycle(($urandom % 4) != 0, longint'($signed(16'($urandom))));
        end

        report();
    end

endmodule